// File: doc/BRIEF.md
# Cell Traffic Generator

This block produces a stream of fixed-length cells whose timing follows one of six patterns chosen by an 8-bit command opcode. A command arrives on a request/acknowledge interface together with a constant gap value and a constant burst length. The block acknowledges a command only between cells. It first sends back a copy of the command as a control cell whose opcode field is one higher than the opcode received, so the sender can confirm receipt. It then alternates silent gaps with bursts of back-to-back cells.

The gap and the burst length are each either the configured constant or a pseudo-random draw. Random gaps come from a 32-bit LFSR and random burst lengths come from a 4-bit LFSR. Each LFSR advances only when one of its values is consumed. While no pattern is running, incoming cells pass straight through to the output. While a pattern runs, incoming cells are discarded.

Top module: `cell_traffic_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid`, `out_soc` and `cmd_ack` are low (with `cmd_req` low).
- R2: `cmd_ack` is high only together with `cmd_req`, and only when no cell is being emitted: idle, in a gap, or at the start of a burst cell. An acknowledged command is taken on that clock edge.
- R3: The cycle after the acknowledge shows no output. The next `CELL_WORDS` cycles carry the control cell: word 0 is `CTRL_HDR`, word 1 is {opcode+1 [31:24], 4'h0 [23:20], burst [19:16], gap zero-extended [15:0]}, and the remaining words are zero.
- R4: Opcode decode. 0x02 gives constant gap with single cells. 0x04 gives random gap with single cells. 0x06 gives constant gap with constant burst. 0x08 gives random gap with constant burst. 0x0A gives constant gap with random burst. 0x0C gives random gap with random burst. 0x00 is idle.
- R5: After the control cell, and after each burst, exactly G+1 cycles with `out_valid` low come before the next burst, where G is the gap in force.
- R6: A random gap is the low `GAP_W` bits of the 32-bit LFSR. The LFSR starts at `GAP_SEED`. Each draw returns the current state and then loads {s[31]^s[21]^s[1]^s[0], s[31:1]}.
- R7: A random burst length is the 4-bit LFSR state. It starts at `LEN_SEED` and each draw loads {s[3]^s[2], s[3:1]}. A burst length of zero, whether constant or random, gives one cell. Single-cell modes always use one cell.
- R8: Cells within a burst follow each other with no idle cycle. Word 0 of a cell is `DATA_HDR`. Word k≥1 is {cell number [31:16], k [15:0]}. The cell number starts at 0 for each command.
- R9: `out_soc` is high exactly on word 0 of every outgoing cell and never without `out_valid`.
- R10: In idle, `in_valid`, `in_data` and `in_soc`&`in_valid` appear on the output one cycle later.
- R11: While a pattern runs (gap or burst), incoming cells never reach the output.
- R12: A command requested in the middle of a cell is acknowledged only after that cell's last word. The cell completes unchanged.
- R13: Any opcode other than the six pattern opcodes is echoed and then leaves the block idle, with pass-through active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 1 | Command request, held until acknowledged |
| cmd_ack | output | 1 | Command taken on this clock edge |
| cmd_opcode | input | 8 | Pattern opcode |
| cmd_gap | input | GAP_W | Constant gap value |
| cmd_burst | input | 4 | Constant burst length |
| in_valid | input | 1 | Incoming word valid |
| in_soc | input | 1 | Incoming start-of-cell |
| in_data | input | DW | Incoming word |
| out_valid | output | 1 | Outgoing word valid |
| out_soc | output | 1 | Outgoing start-of-cell |
| out_data | output | DW | Outgoing word |

## Verification
The bench builds the block with `CELL_WORDS` = 4 and `GAP_W` = 4. Short cells and gaps of at most 16 cycles let every pattern run through several bursts within a few hundred cycles. The 4-bit gap mask makes random gaps of both small and large values appear early in the LFSR sequence. Because the LFSRs advance only on a draw, the bench can predict every random gap and burst length from the seeds alone. Those seeds are passed explicitly, so a wrong tap or a missed step shows up as a mistimed cell.

// File: rtl/ctg_pkg.sv
package ctg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ECHO,
        ST_GAP,
        ST_BURST
    } seq_state_e;

    typedef struct packed {
        logic active;
        logic rand_gap;
        logic multi;
        logic rand_burst;
    } mode_t;

    localparam logic [7:0] OP_IDLE  = 8'h00;
    localparam logic [7:0] OP_CG    = 8'h02;
    localparam logic [7:0] OP_RG    = 8'h04;
    localparam logic [7:0] OP_CG_CB = 8'h06;
    localparam logic [7:0] OP_RG_CB = 8'h08;
    localparam logic [7:0] OP_CG_RB = 8'h0A;
    localparam logic [7:0] OP_RG_RB = 8'h0C;

    localparam int LEN_W = 4;

    function automatic mode_t decode_op(input logic [7:0] op);
        mode_t m;
        m = '0;
        case (op)
            OP_CG:    m = mode_t'(4'b1000);
            OP_RG:    m = mode_t'(4'b1100);
            OP_CG_CB: m = mode_t'(4'b1010);
            OP_RG_CB: m = mode_t'(4'b1110);
            OP_CG_RB: m = mode_t'(4'b1011);
            OP_RG_RB: m = mode_t'(4'b1111);
            default:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ctg_lfsr.sv
module ctg_lfsr #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] TAPS  = '1,
    parameter logic [WIDTH-1:0] SEED  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [WIDTH-1:0] state
);

    logic feedback;

    generate
        if (WIDTH > 1) begin : g_multi
            assign feedback = ^(state & TAPS);
        end else begin : g_single
            assign feedback = ~state[0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (step) begin
            if (WIDTH > 1) begin
                state <= {feedback, state[WIDTH-1:1]};
            end else begin
                state <= feedback;
            end
        end
    end

endmodule

// File: rtl/ctg_sequencer.sv
module ctg_sequencer
    import ctg_pkg::*;
#(
    parameter int CELL_WORDS = 14,
    parameter int GAP_W      = 8,
    localparam int IW        = $clog2(CELL_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  mode_t              mode,
    input  logic [GAP_W-1:0]   cfg_gap,
    input  logic [LEN_W-1:0]   cfg_burst,
    input  logic [GAP_W-1:0]   rnd_gap,
    input  logic [LEN_W-1:0]   rnd_burst,
    output seq_state_e         st,
    output logic [IW-1:0]      widx,
    output logic [LEN_W-1:0]   burst_left,
    output logic [15:0]        cell_seq,
    output logic               emit,
    output logic               boundary,
    output logic               gap_draw,
    output logic               burst_draw
);

    localparam logic [IW-1:0] LAST = IW'(CELL_WORDS - 1);

    logic [GAP_W-1:0] gap_cnt;
    logic [GAP_W-1:0] gap_value;
    logic [LEN_W-1:0] burst_raw;
    logic [LEN_W-1:0] burst_value;
    logic             cell_end;
    logic             load_gap;
    logic             load_burst;

    always_comb begin
        gap_value   = mode.rand_gap ? rnd_gap : cfg_gap;
        if (!mode.multi) begin
            burst_raw = LEN_W'(1);
        end else if (mode.rand_burst) begin
            burst_raw = rnd_burst;
        end else begin
            burst_raw = cfg_burst;
        end
        burst_value = (burst_raw == '0) ? LEN_W'(1) : burst_raw;
        cell_end    = ((st == ST_ECHO) || (st == ST_BURST)) && (widx == LAST);
        load_gap    = !accept && cell_end && mode.active &&
                      ((st == ST_ECHO) || (burst_left == LEN_W'(1)));
        load_burst  = !accept && (st == ST_GAP) && (gap_cnt == '0);
        gap_draw    = load_gap && mode.rand_gap;
        burst_draw  = load_burst && mode.multi && mode.rand_burst;
        boundary    = (st == ST_IDLE) || (st == ST_GAP) ||
                      ((st == ST_BURST) && (widx == '0));
        emit        = !accept && ((st == ST_ECHO) || (st == ST_BURST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            widx       <= '0;
            gap_cnt    <= '0;
            burst_left <= '0;
            cell_seq   <= '0;
        end else if (accept) begin
            st       <= ST_ECHO;
            widx     <= '0;
            cell_seq <= '0;
        end else begin
            case (st)
                ST_ECHO: begin
                    if (widx == LAST) begin
                        widx    <= '0;
                        gap_cnt <= gap_value;
                        st      <= mode.active ? ST_GAP : ST_IDLE;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (load_burst) begin
                        st         <= ST_BURST;
                        burst_left <= burst_value;
                        widx       <= '0;
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                ST_BURST: begin
                    if (widx == LAST) begin
                        widx     <= '0;
                        cell_seq <= cell_seq + 1'b1;
                        if (load_gap) begin
                            st      <= ST_GAP;
                            gap_cnt <= gap_value;
                        end else begin
                            burst_left <= burst_left - 1'b1;
                        end
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                default: begin
                    widx <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ctg_cell_fmt.sv
module ctg_cell_fmt #(
    parameter int            DW         = 32,
    parameter int            CELL_WORDS = 14,
    parameter int            GAP_W      = 8,
    parameter logic [DW-1:0] CTRL_HDR   = '0,
    parameter logic [DW-1:0] DATA_HDR   = '0,
    localparam int           IW         = $clog2(CELL_WORDS)
) (
    input  logic             is_echo,
    input  logic [IW-1:0]    widx,
    input  logic [7:0]       opcode,
    input  logic [GAP_W-1:0] gap,
    input  logic [3:0]       burst,
    input  logic [15:0]      cell_seq,
    output logic [DW-1:0]    word
);

    logic [7:0]  echo_op;
    logic [15:0] gap_ext;

    always_comb begin
        echo_op = opcode + 8'd1;
        gap_ext = 16'(gap);
        if (is_echo) begin
            if (widx == '0) begin
                word = CTRL_HDR;
            end else if (widx == IW'(1)) begin
                word = DW'({echo_op, 4'h0, burst, gap_ext});
            end else begin
                word = '0;
            end
        end else begin
            if (widx == '0) begin
                word = DATA_HDR;
            end else begin
                word = DW'({cell_seq, 16'(widx)});
            end
        end
    end

endmodule

// File: rtl/cell_traffic_gen.sv
module cell_traffic_gen
    import ctg_pkg::*;
#(
    parameter int            DW         = 32,
    parameter int            CELL_WORDS = 14,
    parameter int            GAP_W      = 8,
    parameter logic [DW-1:0] CTRL_HDR   = 32'h0000_0230,
    parameter logic [DW-1:0] DATA_HDR   = 32'h0000_0640,
    parameter logic [31:0]   GAP_SEED   = 32'h1ACE_B00C,
    parameter logic [3:0]    LEN_SEED   = 4'h9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_req,
    output logic             cmd_ack,
    input  logic [7:0]       cmd_opcode,
    input  logic [GAP_W-1:0] cmd_gap,
    input  logic [3:0]       cmd_burst,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic [DW-1:0]    in_data,
    output logic             out_valid,
    output logic             out_soc,
    output logic [DW-1:0]    out_data
);

    localparam int            IW       = $clog2(CELL_WORDS);
    localparam logic [31:0]   GAP_TAPS = 32'h8020_0003;
    localparam logic [3:0]    LEN_TAPS = 4'hC;

    logic [7:0]       op_q;
    logic [GAP_W-1:0] gap_q;
    logic [3:0]       burst_q;
    mode_t            mode_q;

    seq_state_e       seq_st;
    logic [IW-1:0]    widx;
    logic [3:0]       burst_left;
    logic [15:0]      cell_seq;
    logic             emit;
    logic             boundary;
    logic             gap_draw;
    logic             burst_draw;
    logic             accept;
    logic [31:0]      lfsr_gap_q;
    logic [3:0]       lfsr_len_q;
    logic [DW-1:0]    fmt_word;

    assign accept  = cmd_req && boundary;
    assign cmd_ack = accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_IDLE;
            gap_q   <= '0;
            burst_q <= '0;
            mode_q  <= '0;
        end else if (accept) begin
            op_q    <= cmd_opcode;
            gap_q   <= cmd_gap;
            burst_q <= cmd_burst;
            mode_q  <= decode_op(cmd_opcode);
        end
    end

    ctg_lfsr #(
        .WIDTH (32),
        .TAPS  (GAP_TAPS),
        .SEED  (GAP_SEED)
    ) u_gap_rng (
        .clk   (clk),
        .rst   (rst),
        .step  (gap_draw),
        .state (lfsr_gap_q)
    );

    ctg_lfsr #(
        .WIDTH (4),
        .TAPS  (LEN_TAPS),
        .SEED  (LEN_SEED)
    ) u_len_rng (
        .clk   (clk),
        .rst   (rst),
        .step  (burst_draw),
        .state (lfsr_len_q)
    );

    ctg_sequencer #(
        .CELL_WORDS (CELL_WORDS),
        .GAP_W      (GAP_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .mode       (mode_q),
        .cfg_gap    (gap_q),
        .cfg_burst  (burst_q),
        .rnd_gap    (lfsr_gap_q[GAP_W-1:0]),
        .rnd_burst  (lfsr_len_q),
        .st         (seq_st),
        .widx       (widx),
        .burst_left (burst_left),
        .cell_seq   (cell_seq),
        .emit       (emit),
        .boundary   (boundary),
        .gap_draw   (gap_draw),
        .burst_draw (burst_draw)
    );

    ctg_cell_fmt #(
        .DW         (DW),
        .CELL_WORDS (CELL_WORDS),
        .GAP_W      (GAP_W),
        .CTRL_HDR   (CTRL_HDR),
        .DATA_HDR   (DATA_HDR)
    ) u_fmt (
        .is_echo  (seq_st == ST_ECHO),
        .widx     (widx),
        .opcode   (op_q),
        .gap      (gap_q),
        .burst    (burst_q),
        .cell_seq (cell_seq),
        .word     (fmt_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_soc   <= (widx == '0);
            out_data  <= fmt_word;
        end else if ((seq_st == ST_IDLE) && !accept) begin
            out_valid <= in_valid;
            out_soc   <= in_valid && in_soc;
            out_data  <= in_data;
        end else begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end
    end

endmodule

// File: rtl/ctg_checker.sv
module ctg_checker
    import ctg_pkg::*;
#(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] CTRL_HDR = '0
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_req,
    input logic          cmd_ack,
    input logic          out_valid,
    input logic          out_soc,
    input logic [DW-1:0] out_data,
    input seq_state_e    st,
    input logic [3:0]    burst_left,
    input logic [31:0]   rng_gap_state,
    input logic [3:0]    rng_len_state
);

    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |-> cmd_req);

    assert_no_ack_in_echo_R12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ECHO) |-> !cmd_ack);

    assert_echo_header_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |=> ##1 (out_valid && out_soc && (out_data == CTRL_HDR)));

    assert_soc_has_valid_R9: assert property (@(posedge clk) disable iff (rst)
        out_soc |-> out_valid);

    assert_burst_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BURST) |-> (burst_left != 4'd0));

    assert_rng_live_R6: assert property (@(posedge clk) disable iff (rst)
        (rng_gap_state != 32'd0) && (rng_len_state != 4'd0));

    assert_gap_silent_R11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |=> !out_valid);

endmodule

bind cell_traffic_gen ctg_checker #(
    .DW       (DW),
    .CTRL_HDR (CTRL_HDR)
) u_ctg_checker (
    .clk           (clk),
    .rst           (rst),
    .cmd_req       (cmd_req),
    .cmd_ack       (cmd_ack),
    .out_valid     (out_valid),
    .out_soc       (out_soc),
    .out_data      (out_data),
    .st            (seq_st),
    .burst_left    (burst_left),
    .rng_gap_state (lfsr_gap_q),
    .rng_len_state (lfsr_len_q)
);

// File: tb/test_cell_traffic_gen.sv
module test_cell_traffic_gen;

    localparam int          CLK_PERIOD = 10;
    localparam int          DW         = 32;
    localparam int          CW         = 4;
    localparam int          GAP_W      = 4;
    localparam logic [31:0] CTRL_HDR   = 32'hC0DE_0023;
    localparam logic [31:0] DATA_HDR   = 32'hDA7A_0077;
    localparam logic [31:0] GAP_SEED   = 32'h1ACE_B00C;
    localparam logic [3:0]  LEN_SEED   = 4'h9;

    // vector: opcode, constant gap, constant burst, bursts to observe
    localparam logic [19:0] VECS [0:7] = '{
        {8'h02, 4'd3, 4'd0, 4'd3},
        {8'h04, 4'd0, 4'd0, 4'd3},
        {8'h06, 4'd1, 4'd2, 4'd2},
        {8'h08, 4'd0, 4'd3, 4'd2},
        {8'h0A, 4'd0, 4'd0, 4'd3},
        {8'h0C, 4'd0, 4'd0, 4'd3},
        {8'h06, 4'd2, 4'd0, 4'd2},
        {8'h00, 4'd5, 4'd5, 4'd0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_req = 1'b0;
    logic             cmd_ack;
    logic [7:0]       cmd_opcode = 8'h00;
    logic [GAP_W-1:0] cmd_gap = '0;
    logic [3:0]       cmd_burst = '0;
    logic             in_valid = 1'b0;
    logic             in_soc = 1'b0;
    logic [DW-1:0]    in_data = '0;
    logic             out_valid;
    logic             out_soc;
    logic [DW-1:0]    out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_gap = GAP_SEED;
    logic [3:0]  m_len = LEN_SEED;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_traffic_gen #(
        .DW         (DW),
        .CELL_WORDS (CW),
        .GAP_W      (GAP_W),
        .CTRL_HDR   (CTRL_HDR),
        .DATA_HDR   (DATA_HDR),
        .GAP_SEED   (GAP_SEED),
        .LEN_SEED   (LEN_SEED)
    ) i_cell_traffic_gen (
        .clk        (clk),
        .rst        (rst),
        .cmd_req    (cmd_req),
        .cmd_ack    (cmd_ack),
        .cmd_opcode (cmd_opcode),
        .cmd_gap    (cmd_gap),
        .cmd_burst  (cmd_burst),
        .in_valid   (in_valid),
        .in_soc     (in_soc),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_soc    (out_soc),
        .out_data   (out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] step_gap(input logic [31:0] s);
        return {s[31] ^ s[21] ^ s[1] ^ s[0], s[31:1]};
    endfunction

    function automatic logic [3:0] step_len(input logic [3:0] s);
        return {s[3] ^ s[2], s[3:1]};
    endfunction

    // raise a command now (at a falling edge), wait for acknowledge, leave at the cycle after acceptance
    task automatic issue(input logic [7:0] op, input logic [3:0] g, input logic [3:0] b);
        cmd_req    = 1'b1;
        cmd_opcode = op;
        cmd_gap    = g;
        cmd_burst  = b;
        #1;
        while (!cmd_ack) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cmd_req = 1'b0;
        chk(!out_valid, "R3 idle cycle after acknowledge", 32'(out_valid), 32'd0);
    endtask

    task automatic check_echo(input logic [7:0] op, input logic [3:0] g, input logic [3:0] b);
        logic [31:0] exp;
        for (int k = 0; k < CW; k++) begin
            @(negedge clk);
            if (k == 0)      exp = CTRL_HDR;
            else if (k == 1) exp = {op + 8'd1, 4'h0, b, 16'(g)};
            else             exp = 32'd0;
            chk(out_valid, "R3 echo valid", 32'(out_valid), 32'd1);
            chk(out_soc == (k == 0), "R9 echo start-of-cell", 32'(out_soc), 32'(k == 0));
            chk(out_data == exp, "R3 echo word", out_data, exp);
        end
    endtask

    task automatic check_cell(input logic [15:0] seq, input string tag);
        logic [31:0] exp;
        for (int k = 0; k < CW; k++) begin
            @(negedge clk);
            exp = (k == 0) ? DATA_HDR : {seq, 16'(k)};
            chk(out_valid, tag, 32'(out_valid), 32'd1);
            chk(out_soc == (k == 0), "R9 cell start-of-cell", 32'(out_soc), 32'(k == 0));
            chk(out_data == exp, tag, out_data, exp);
        end
    endtask

    task automatic run_pattern(input logic [7:0] op, input logic [3:0] g, input logic [3:0] b, input int nb);
        bit act, rg, multi, rb;
        int gap, len;
        logic [15:0] seq;
        string tag;
        act   = (op == 8'h02) || (op == 8'h04) || (op == 8'h06) ||
                (op == 8'h08) || (op == 8'h0A) || (op == 8'h0C);
        rg    = (op == 8'h04) || (op == 8'h08) || (op == 8'h0C);
        multi = act && (op >= 8'h06);
        rb    = (op == 8'h0A) || (op == 8'h0C);
        tag   = rb ? "R7 random burst cell" : (multi ? "R8 burst cell" : "R4 single cell");
        seq   = 16'd0;
        for (int i = 0; i < nb; i++) begin
            if (rg) begin
                gap   = int'(m_gap[GAP_W-1:0]);
                m_gap = step_gap(m_gap);
            end else begin
                gap = int'(g);
            end
            for (int c = 0; c <= gap; c++) begin
                @(negedge clk);
                chk(!out_valid, rg ? "R6 random gap idle" : "R5 constant gap idle", 32'(out_valid), 32'd0);
            end
            if (!multi) begin
                len = 1;
            end else if (rb) begin
                len   = int'(m_len);
                m_len = step_len(m_len);
            end else begin
                len = int'(b);
            end
            if (len == 0) len = 1;
            for (int n = 0; n < len; n++) begin
                check_cell(seq, tag);
                seq++;
            end
        end
        if (act && rg) m_gap = step_gap(m_gap);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] op;
        logic [3:0] g, b, nb;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_soc, "R1 outputs low in reset", {out_valid, out_soc}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !out_soc, "R1 outputs low after reset", {out_valid, out_soc}, 32'd0);
        chk(!cmd_ack, "R1 no acknowledge without request", 32'(cmd_ack), 32'd0);

        // table of patterns
        for (int v = 0; v < 8; v++) begin
            op = VECS[v][19:12];
            g  = VECS[v][11:8];
            b  = VECS[v][7:4];
            nb = VECS[v][3:0];
            issue(op, g, b);
            check_echo(op, g, b);
            run_pattern(op, g, b, int'(nb));
        end

        // R10: pass-through while idle (after opcode 0x00)
        in_valid = 1'b1; in_soc = 1'b1; in_data = 32'h1234_0001;
        @(negedge clk);
        chk(out_valid && out_soc && out_data == 32'h1234_0001, "R10 pass-through first word", out_data, 32'h1234_0001);
        in_soc = 1'b0; in_data = 32'h1234_0002;
        @(negedge clk);
        chk(out_valid && !out_soc && out_data == 32'h1234_0002, "R10 pass-through next word", out_data, 32'h1234_0002);
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R10 pass-through invalid word", 32'(out_valid), 32'd0);

        // R11: traffic dropped while a pattern runs
        issue(8'h02, 4'd5, 4'd0);
        check_echo(8'h02, 4'd5, 4'd0);
        for (int c = 0; c <= 5; c++) begin
            in_valid = 1'b1; in_soc = (c == 0); in_data = 32'hBAD0_0000 + 32'(c);
            @(negedge clk);
            chk(!out_valid, "R11 input dropped during gap", 32'(out_valid), 32'd0);
        end
        in_valid = 1'b1; in_soc = 1'b1; in_data = 32'hBAD0_00FF;
        @(negedge clk);
        chk(out_valid && out_soc && out_data == DATA_HDR, "R11 generated cell not input", out_data, DATA_HDR);
        in_valid = 1'b0; in_soc = 1'b0;

        // R12: command raised mid-cell waits for the cell boundary; R13 unknown opcode
        cmd_req = 1'b1; cmd_opcode = 8'h03; cmd_gap = 4'd1; cmd_burst = 4'd2;
        #1;
        chk(!cmd_ack, "R12 no acknowledge mid-cell", 32'(cmd_ack), 32'd0);
        for (int k = 1; k < CW; k++) begin
            @(negedge clk);
            #1;
            chk(out_valid && out_data == {16'd0, 16'(k)}, "R12 cell completes", out_data, {16'd0, 16'(k)});
            chk(cmd_ack == (k == CW - 1), "R12 acknowledge at boundary", 32'(cmd_ack), 32'(k == CW - 1));
        end
        @(negedge clk);
        cmd_req = 1'b0;
        chk(!out_valid, "R12 idle cycle after acknowledge", 32'(out_valid), 32'd0);
        check_echo(8'h03, 4'd1, 4'd2);
        in_valid = 1'b1; in_soc = 1'b1; in_data = 32'hCAFE_0013;
        @(negedge clk);
        chk(out_valid && out_data == 32'hCAFE_0013, "R13 unknown opcode leaves block idle", out_data, 32'hCAFE_0013);
        in_valid = 1'b0; in_soc = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R13 no generated traffic", 32'(out_valid), 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule